// File: doc/BRIEF.md
# Accumulator Slot Execution Unit

This unit executes the 6-bit accumulator field of a wide instruction word. Each clock it takes the field's operation code, the current accumulator and the read-only operand registers owned by other slots (BX, DX, LX, the 5-bit frame pointer LF and the carry flag). It computes the next accumulator value and registers it. The operations are moves, add and subtract, logic, increment and decrement, invert and negate, left shift, byte swap, byte mask, a carry-gated add, and loads from a fixed table of immediate constants chosen by the code itself.

Every operation takes one cycle. The unit writes only the accumulator and produces no flags. Arithmetic wraps modulo 2^16. Operand inputs are sampled at the same rising edge that writes the result.

Top module: `accum_slot`

## Requirements
- R1: Code 0 (no operation) leaves `ax_q` unchanged at the next edge.
- R2: While `rst` is high at a rising edge, `ax_q` becomes 0 at that edge.
- R3: Code 5 adds `bx_i` to the accumulator when `cf_i` is 1, and leaves it unchanged when `cf_i` is 0. The carry flag is never written.
- R4: The add and subtract codes wrap modulo 2^16:
  - 6 is AX+BX and 7 is AX-BX.
  - 8 is AX+DX.
  - 17 is AX+LX and 18 is AX-LX.
- R5: The single-operand codes act on AX alone:
  - 12 is AX+1 and 13 is AX-1.
  - 14 is AX XOR FFFF.
  - 15 is 0-AX.
  - 16 shifts AX left by one place and fills the low bit with 0.
- R6: Code 22 exchanges the high and low bytes of AX. Code 23 ANDs AX with 00FF.
- R7: The logic codes are AND, OR and XOR:
  - 9, 10 and 11 take BX as the second operand.
  - 19, 20 and 21 take LX as the second operand.
- R8: The move codes copy one register into AX:
  - 1 copies LX and 2 copies BX.
  - 3 copies DX.
  - 4 copies LF zero-extended to 16 bits.
- R9: Codes 24 to 63 load constants in four ranges:
  - 24..34 load the values 0..10.
  - 35..42 load 20, 30 and so on up to 90.
  - 43..51 load 100, 200 and so on up to 900.
  - 52..63 load 0x0010 << (code-52).
- R10: The result of the code present before a rising edge is visible on `ax_q` just after that edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 6 | Accumulator-slot operation code |
| cf_i | input | 1 | Carry flag, read only |
| bx_i | input | 16 | BX operand |
| dx_i | input | 16 | DX operand |
| lx_i | input | 16 | LX operand |
| lf_i | input | 5 | Frame pointer operand |
| ax_q | output | 16 | Registered accumulator |

## Verification
The hardest results to reach from the ports are the wrap-around values: negating or decrementing zero, incrementing FFFF, and a carry-gated add with the flag clear after the accumulator already holds a nonzero value. A purely random AX seldom lands on these. Directed sequences therefore first load AX through a constant or move code, then apply the corner operation. Constrained random codes then run long chains in which each result feeds the next operation, so every code is seen with many accumulator histories.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int OP_W      = 6;
  localparam int IMM_COUNT = 40;
  localparam logic [OP_W-1:0] IMM_BASE = 6'd24;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 6'd0,  OP_MOV_LX = 6'd1,  OP_MOV_BX = 6'd2,  OP_MOV_DX = 6'd3,
    OP_MOV_LF = 6'd4,  OP_CSUM   = 6'd5,  OP_ADD_B  = 6'd6,  OP_SUB_B  = 6'd7,
    OP_ADD_D  = 6'd8,  OP_AND_B  = 6'd9,  OP_OR_B   = 6'd10, OP_XOR_B  = 6'd11,
    OP_INC    = 6'd12, OP_DEC    = 6'd13, OP_INV    = 6'd14, OP_NEG    = 6'd15,
    OP_SHL    = 6'd16, OP_ADD_L  = 6'd17, OP_SUB_L  = 6'd18, OP_AND_L  = 6'd19,
    OP_OR_L   = 6'd20, OP_XOR_L  = 6'd21, OP_SWAP   = 6'd22, OP_BMASK  = 6'd23
  } acc_op_e;

  // Constant for table slot k (R9): units, tens, hundreds, then bit masks.
  function automatic int unsigned imm_of(int unsigned k);
    if (k <= 10)      return k;
    else if (k <= 18) return (k - 9) * 10;
    else if (k <= 27) return (k - 18) * 100;
    else              return 32'd16 << (k - 28);
  endfunction
endpackage

// File: rtl/accum_const_rom.sv
module accum_const_rom
  import accum_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op_i,
  output logic            hit_o,
  output logic [W-1:0]    imm_o
);
  localparam logic [OP_W-1:0] LAST = IMM_BASE + OP_W'(IMM_COUNT - 1);

  logic [W-1:0]    tbl [IMM_COUNT];
  logic [OP_W-1:0] idx;

  for (genvar k = 0; k < IMM_COUNT; k++) begin : g_tbl
    assign tbl[k] = W'(imm_of(k));
  end

  assign hit_o = (op_i >= IMM_BASE) && (op_i <= LAST);
  assign idx   = op_i - IMM_BASE;
  assign imm_o = hit_o ? tbl[idx] : '0;
endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OP_W-1:0] op_i,
  input  logic            cf_i,
  input  logic [W-1:0]    ax_i,
  input  logic [W-1:0]    bx_i,
  input  logic [W-1:0]    dx_i,
  input  logic [W-1:0]    lx_i,
  input  logic [W-1:0]    lf_i,
  input  logic            imm_hit_i,
  input  logic [W-1:0]    imm_i,
  output logic [W-1:0]    ax_o
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{(W-HALF){1'b0}}, {HALF{1'b1}}};

  always_comb begin
    ax_o = ax_i;
    if (imm_hit_i) begin
      ax_o = imm_i;
    end else begin
      unique case (acc_op_e'(op_i))
        OP_NOP:    ax_o = ax_i;
        OP_MOV_LX: ax_o = lx_i;
        OP_MOV_BX: ax_o = bx_i;
        OP_MOV_DX: ax_o = dx_i;
        OP_MOV_LF: ax_o = lf_i;
        OP_CSUM:   ax_o = cf_i ? ax_i + bx_i : ax_i;
        OP_ADD_B:  ax_o = ax_i + bx_i;
        OP_SUB_B:  ax_o = ax_i - bx_i;
        OP_ADD_D:  ax_o = ax_i + dx_i;
        OP_AND_B:  ax_o = ax_i & bx_i;
        OP_OR_B:   ax_o = ax_i | bx_i;
        OP_XOR_B:  ax_o = ax_i ^ bx_i;
        OP_INC:    ax_o = ax_i + 1'b1;
        OP_DEC:    ax_o = ax_i - 1'b1;
        OP_INV:    ax_o = ~ax_i;
        OP_NEG:    ax_o = '0 - ax_i;
        OP_SHL:    ax_o = {ax_i[W-2:0], 1'b0};
        OP_ADD_L:  ax_o = ax_i + lx_i;
        OP_SUB_L:  ax_o = ax_i - lx_i;
        OP_AND_L:  ax_o = ax_i & lx_i;
        OP_OR_L:   ax_o = ax_i | lx_i;
        OP_XOR_L:  ax_o = ax_i ^ lx_i;
        OP_SWAP:   ax_o = {ax_i[HALF-1:0], ax_i[W-1:HALF]};
        OP_BMASK:  ax_o = ax_i & LOW_MASK;
        default:   ax_o = ax_i;
      endcase
    end
  end
endmodule

// File: rtl/accum_slot.sv
module accum_slot
  import accum_pkg::*;
#(
  parameter int W    = 16,
  parameter int LF_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op_i,
  input  logic            cf_i,
  input  logic [W-1:0]    bx_i,
  input  logic [W-1:0]    dx_i,
  input  logic [W-1:0]    lx_i,
  input  logic [LF_W-1:0] lf_i,
  output logic [W-1:0]    ax_q
);
  localparam logic [OP_W-1:0] MASK_FIRST = IMM_BASE + 6'd28;

  logic [W-1:0] lf_ext, imm, ax_d;
  logic         imm_hit;

  assign lf_ext = {{(W-LF_W){1'b0}}, lf_i};

  accum_const_rom #(.W(W)) i_rom (
    .op_i (op_i),
    .hit_o(imm_hit),
    .imm_o(imm)
  );

  accum_alu #(.W(W)) i_alu (
    .op_i     (op_i),
    .cf_i     (cf_i),
    .ax_i     (ax_q),
    .bx_i     (bx_i),
    .dx_i     (dx_i),
    .lx_i     (lx_i),
    .lf_i     (lf_ext),
    .imm_hit_i(imm_hit),
    .imm_i    (imm),
    .ax_o     (ax_d)
  );

  always_ff @(posedge clk) begin
    if (rst) ax_q <= '0;
    else     ax_q <= ax_d;
  end

  p_reset_zero_r2: assert property (@(posedge clk) rst |=> ax_q == '0);
  p_nop_hold_r1: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_NOP |=> $stable(ax_q));
  p_csum_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_CSUM && !cf_i) |=> $stable(ax_q));
  p_shl_fill_r5: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_SHL |=> ax_q[0] == 1'b0);
  p_bmask_high_r6: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_BMASK |=> ax_q[W-1:W/2] == '0);
  p_mask_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    op_i >= MASK_FIRST |=> $countones(ax_q) == 1);
  p_move_bx_r8: assert property (@(posedge clk) disable iff (rst)
    op_i == OP_MOV_BX |=> ax_q == $past(bx_i));
endmodule

// File: tb/test_accum_slot.sv
`timescale 1ns/1ps
module test_accum_slot;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  op;
  logic        cf;
  logic [15:0] bx, dx, lx;
  logic [4:0]  lf;
  logic [15:0] ax;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_ax;
  bit done = 0;

  accum_slot i_accum_slot (
    .clk(clk), .rst(rst), .op_i(op), .cf_i(cf), .bx_i(bx), .dx_i(dx),
    .lx_i(lx), .lf_i(lf), .ax_q(ax)
  );

  always #2 clk = ~clk;

  function automatic string req_of(logic [5:0] c);
    if (c == 0) return "R1";
    if (c == 5) return "R3";
    if (c >= 24) return "R9";
    if (c inside {6, 7, 8, 17, 18}) return "R4";
    if (c inside {12, 13, 14, 15, 16}) return "R5";
    if (c inside {22, 23}) return "R6";
    if (c inside {9, 10, 11, 19, 20, 21}) return "R7";
    return "R8";
  endfunction

  function automatic logic [15:0] konst(int k);
    int unsigned v;
    if (k < 11)      v = k;
    else if (k < 19) v = 20 + 10 * (k - 11);
    else if (k < 28) v = 100 + 100 * (k - 19);
    else             v = 1 << (k - 24);
    return v[15:0];
  endfunction

  function automatic logic [15:0] model(logic [5:0] c, logic [15:0] a);
    case (c)
      0: return a;
      1: return lx;
      2: return bx;
      3: return dx;
      4: return {11'd0, lf};
      5: return cf ? a + bx : a;
      6: return a + bx;
      7: return a - bx;
      8: return a + dx;
      9: return a & bx;
      10: return a | bx;
      11: return a ^ bx;
      12: return a + 16'd1;
      13: return a - 16'd1;
      14: return a ^ 16'hFFFF;
      15: return 16'd0 - a;
      16: return a << 1;
      17: return a + lx;
      18: return a - lx;
      19: return a & lx;
      20: return a | lx;
      21: return a ^ lx;
      22: return {a[7:0], a[15:8]};
      23: return a & 16'h00FF;
      default: return konst(int'(c) - 24);
    endcase
  endfunction

  task automatic check(string req, logic [15:0] want);
    checks++;
    if (ax !== want) begin
      errors++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, op, ax, want);
    end
  endtask

  // Inputs change at the falling edge; the result is sampled at the next
  // falling edge, half a period after the rising edge that registers it (R10).
  task automatic step(logic [5:0] c, logic f, logic [15:0] b, logic [15:0] d,
                      logic [15:0] l, logic [4:0] p);
    op = c; cf = f; bx = b; dx = d; lx = l; lf = p;
    exp_ax = model(c, exp_ax);
    @(negedge clk);
    check(req_of(c), exp_ax);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1; op = 0; cf = 0; bx = 0; dx = 0; lx = 0; lf = 0;
    exp_ax = 16'h0000;
    repeat (3) @(negedge clk);
    check("R2", 16'h0000);
    rst = 0;

    // Directed corner cases.
    step(15, 0, 16'h1, 16'h2, 16'h3, 5'd1);        // R5 negate zero
    step(13, 0, 16'h1, 16'h2, 16'h3, 5'd1);        // R5 decrement zero -> FFFF
    step(12, 0, 16'h1, 16'h2, 16'h3, 5'd1);        // R5 increment FFFF -> 0
    step(33, 0, 16'h0, 16'h0, 16'h0, 5'd0);        // R9 value 9
    step(5, 0, 16'h1234, 16'h0, 16'h0, 5'd0);      // R3 gated off
    step(5, 1, 16'h1234, 16'h0, 16'h0, 5'd0);      // R3 gated on
    step(0, 1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 5'd31); // R1 hold
    step(2, 0, 16'hFFFF, 16'h0, 16'h0, 5'd0);      // R8 move BX
    step(6, 0, 16'h0001, 16'h0, 16'h0, 5'd0);      // R4 wrap add
    step(4, 0, 16'h0, 16'h0, 16'h0, 5'd31);        // R8 move LF
    step(22, 0, 16'h0, 16'h0, 16'h0, 5'd0);        // R6 swap
    step(1, 0, 16'h0, 16'h0, 16'hA5C3, 5'd0);      // R8 move LX
    step(22, 0, 16'h0, 16'h0, 16'h0, 5'd0);        // R6 swap
    step(23, 0, 16'h0, 16'h0, 16'h0, 5'd0);        // R6 byte mask
    step(63, 0, 16'h0, 16'h0, 16'h0, 5'd0);        // R9 0x8000
    step(16, 0, 16'h0, 16'h0, 16'h0, 5'd0);        // R5 shift out msb
    for (int c = 24; c < 64; c++) step(6'(c), 0, 16'h0, 16'h0, 16'h0, 5'd0); // R9 table
    step(8, 0, 16'h0, 16'hFFF0, 16'h0, 5'd0);      // R4 add DX
    step(18, 0, 16'h0, 16'h0, 16'h7FFF, 5'd0);     // R4 subtract LX
    step(14, 0, 16'h0, 16'h0, 16'h0, 5'd0);        // R5 invert

    // Constrained random chains, biased toward small operands and CF mixes.
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] rb, rd, rl;
      rb = ($urandom % 4 == 0) ? 16'(($urandom % 3) - 1) : 16'($urandom);
      rd = 16'($urandom);
      rl = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
      step(6'($urandom % 64), 1'($urandom), rb, rd, rl, 5'($urandom));
    end

    // Reset in mid-run (R2).
    rst = 1; op = 6'd40;
    @(negedge clk);
    check("R2", 16'h0000);
    rst = 0; exp_ax = 16'h0000;
    step(0, 0, 16'h0, 16'h0, 16'h0, 5'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule